// File: doc/BRIEF.md
# PPS Exchange Catcher

This block watches the character stream recovered by a passive smart-card line receiver. It starts watching when the card's reset line rises. It follows the answer-to-reset (ATR) far enough to find its final byte. It then follows the protocol and parameters selection (PPS) request and the card's PPS response, one byte at a time.

When the response's check byte arrives and every earlier byte fits the expected layout, the block does two things. It marks that character with an action flag. If the response carried a rate byte whose clock-rate and baud-divisor indices the block supports, it also loads a new half-etu count into the receiver. The load lands in the cycle right after the check byte, so the receiver samples the next character at the new rate and no bits are lost. The half-etu count is the number of card clock cycles in half of one elementary time unit.

After that final byte, or after any byte that breaks the expected layout, the block stays silent until the next session start. Each session start also reloads the default half-etu count. The check byte values themselves are not verified.

Top module: `pps_rate_tracker`

## Requirements
- R1: While `rst_n` is low, `hetu_load` and `chr_act` are 0 and `hetu_val` holds DEF_HETU (186). Until the first `sess_start` after reset, no character produces a load or an action.
- R2: One cycle after `sess_start`, `hetu_load` is 1, `hetu_val` equals DEF_HETU and `chr_act` is 0. Parsing then restarts from the first ATR byte, even in the middle of an exchange.
- R3: If the first character of a session is not 0x3B, the block stays inactive until the next `sess_start`.
- R4: The ATR ends at the correct byte. T0's low nibble is the number of historical bytes. T0's high nibble and the high nibble of each TDi flag TA, TB, TC and TD in bits 4, 5, 6 and 7. A final TCK byte is present if the low nibble of any TDi is nonzero.
- R5: The first character after the ATR must be 0xFF, otherwise the block becomes inactive.
- R6: In the request, bits 4, 5 and 6 of the format byte each flag one optional byte. That many bytes, and then one check byte, follow before the response begins.
- R7: The response must begin with 0xFF, otherwise the block becomes inactive and raises no action.
- R8: The response check byte of a valid exchange makes `chr_act` pulse for one cycle, one cycle after its `chr_valid`. This happens at most once per session.
- R9: Rate change. The rate byte has the Fi index in its high nibble and the Di index in its low nibble. Fi indices 0..6 give 372, 372, 558, 744, 1116, 1488, 1860, and 9..13 give 512, 768, 1024, 1536, 2048. Di indices 1..7 give 1, 2, 4, 8, 16, 32, 64. If the response format byte has bit 4 set and both indices are supported, `hetu_load` pulses together with `chr_act`, and `hetu_val` becomes floor(F / (2·D)).
- R10: A response without a rate byte, or with an unsupported Fi or Di index, raises `chr_act` without `hetu_load`. `hetu_val` keeps its value.
- R11: After the action, or after the block becomes inactive, no character produces a load or an action until `sess_start`.
- R12: `hetu_load` and `chr_act` are one-cycle strobes that appear only one cycle after `chr_valid` or `sess_start`. If both inputs arrive in the same cycle, `sess_start` wins and the character is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sess_start | input | 1 | One-cycle pulse on the card reset line's rising edge |
| chr_valid | input | 1 | One-cycle strobe: a received character is on `chr_data` |
| chr_data | input | 8 | Received character, bits as sampled |
| hetu_load | output | 1 | Strobe: the receiver loads `hetu_val` |
| hetu_val | output | HETU_W | Half-etu count in card clock cycles |
| chr_act | output | 1 | Marks the character that completed a valid exchange |

## Verification
Every result is due exactly one clock after the strobe that causes it. This holds for the load and default value after `sess_start`, and for the action and optional load after the response check byte. The bench drives each strobe on a falling edge and samples at the next falling edge, so each sample falls after the single register stage. It records the index of each character that produced a strobe, so a parser that ends the ATR one byte early or late fails on position, not just on presence. A sweep over all 256 rate-byte values compares each load value with floor(F / (2·D)), computed by the bench itself.

// File: rtl/pps_catch_pkg.sv
// Shared types and helpers for the PPS exchange catcher.
// Assumes characters arrive in direct convention, unmodified.
package pps_catch_pkg;

    typedef enum logic [3:0] {
        ST_OFF,      // inactive until next session start
        ST_TS,       // waiting for initial character
        ST_T0,       // format character
        ST_IFB,      // interface bytes of the current group
        ST_HIST,     // historical bytes
        ST_TCK,      // ATR check byte
        ST_REQ_HDR,  // request start byte
        ST_REQ_FMT,  // request format byte
        ST_REQ_OPT,  // request optional bytes
        ST_REQ_CHK,  // request check byte
        ST_RSP_HDR,  // response start byte
        ST_RSP_FMT,  // response format byte
        ST_RSP_OPT,  // response optional bytes
        ST_RSP_CHK   // response check byte
    } catch_st_t;

    localparam logic [7:0] TS_DIRECT = 8'h3B;
    localparam logic [7:0] PPS_START = 8'hFF;

    // Number of set bits in a nibble.
    function automatic logic [2:0] ones4(input logic [3:0] v);
        return 3'(v[0]) + 3'(v[1]) + 3'(v[2]) + 3'(v[3]);
    endfunction

    // State that follows the last interface byte of the ATR.
    function automatic catch_st_t after_ifc(input logic [3:0] k, input logic tck);
        if (k != 4'd0)
            return ST_HIST;
        else if (tck)
            return ST_TCK;
        else
            return ST_REQ_HDR;
    endfunction

endpackage

// File: rtl/pps_rate_lut.sv
// Rate-byte decoder: maps the Fi (high nibble) and Di (low nibble)
// indices of a PPS rate byte to a half-etu count F/(2*D).
// Assumes only power-of-two D values (indices 1..7) are supported,
// so the division is a right shift by the Di index.
module pps_rate_lut #(
    parameter int HETU_W = 12
) (
    input  logic [7:0]        rate_byte,
    output logic [HETU_W-1:0] hetu,
    output logic              rate_ok
);

    logic [HETU_W-1:0] f_clk;
    logic              f_ok;
    logic              d_ok;

    // Clock-rate factor lookup from the Fi index.
    always_comb begin
        f_ok  = 1'b1;
        f_clk = '0;
        case (rate_byte[7:4])
            4'd0, 4'd1: f_clk = HETU_W'(372);
            4'd2:       f_clk = HETU_W'(558);
            4'd3:       f_clk = HETU_W'(744);
            4'd4:       f_clk = HETU_W'(1116);
            4'd5:       f_clk = HETU_W'(1488);
            4'd6:       f_clk = HETU_W'(1860);
            4'd9:       f_clk = HETU_W'(512);
            4'd10:      f_clk = HETU_W'(768);
            4'd11:      f_clk = HETU_W'(1024);
            4'd12:      f_clk = HETU_W'(1536);
            4'd13:      f_clk = HETU_W'(2048);
            default:    f_ok  = 1'b0;
        endcase
    end

    // Divisor index must be a power-of-two entry, 1..7.
    assign d_ok    = (rate_byte[3] == 1'b0) && (rate_byte[2:0] != 3'd0);
    assign rate_ok = f_ok && d_ok;
    assign hetu    = f_clk >> rate_byte[2:0];

endmodule

// File: rtl/pps_catch_fsm.sv
// Real-time parser for ATR, PPS request and PPS response.
// Raises exch_done combinationally while the response check byte is
// presented, and keeps the response rate byte once seen.
// Assumes chr_valid is a one-cycle strobe per character and that
// sess_start takes priority over any character in the same cycle.
module pps_catch_fsm
    import pps_catch_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sess_start,
    input  logic       chr_valid,
    input  logic [7:0] chr_data,
    output logic       exch_done,
    output logic [7:0] rate_byte,
    output logic       rate_seen
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    catch_st_t        st_q, st_n;
    logic [CNT_W-1:0] left_q, left_n;
    logic             tdl_q, tdl_n;
    logic             tck_q, tck_n;
    logic [3:0]       hist_q, hist_n;
    logic [2:0]       rflg_q, rflg_n;
    logic [7:0]       rate_q, rate_n;
    logic             rseen_q, rseen_n;
    logic [3:0]       y_nib;
    logic [2:0]       y_cnt;
    logic [2:0]       opt_cnt;

    assign y_nib   = chr_data[7:4];
    assign y_cnt   = ones4(y_nib);
    assign opt_cnt = ones4({1'b0, chr_data[6:4]});

    // Next-state and field-capture logic for one received character.
    always_comb begin
        st_n      = st_q;
        left_n    = left_q;
        tdl_n     = tdl_q;
        tck_n     = tck_q;
        hist_n    = hist_q;
        rflg_n    = rflg_q;
        rate_n    = rate_q;
        rseen_n   = rseen_q;
        exch_done = 1'b0;
        if (sess_start) begin
            st_n    = ST_TS;
            tck_n   = 1'b0;
            rseen_n = 1'b0;
            rflg_n  = '0;
        end else if (chr_valid) begin
            case (st_q)
                ST_TS: st_n = (chr_data == TS_DIRECT) ? ST_T0 : ST_OFF;
                ST_T0: begin
                    hist_n = chr_data[3:0];
                    if (y_cnt != 3'd0) begin
                        left_n = CNT_W'(y_cnt);
                        tdl_n  = y_nib[3];
                        st_n   = ST_IFB;
                    end else begin
                        left_n = CNT_W'(chr_data[3:0]);
                        st_n   = after_ifc(chr_data[3:0], tck_q);
                    end
                end
                ST_IFB: begin
                    if (left_q != ONE) begin
                        left_n = left_q - ONE;
                    end else if (tdl_q) begin
                        // Last byte of the group is TD: open the next group.
                        tck_n = tck_q | (chr_data[3:0] != 4'd0);
                        if (y_cnt != 3'd0) begin
                            left_n = CNT_W'(y_cnt);
                            tdl_n  = y_nib[3];
                        end else begin
                            left_n = CNT_W'(hist_q);
                            st_n   = after_ifc(hist_q, tck_q | (chr_data[3:0] != 4'd0));
                        end
                    end else begin
                        left_n = CNT_W'(hist_q);
                        st_n   = after_ifc(hist_q, tck_q);
                    end
                end
                ST_HIST: begin
                    if (left_q != ONE)
                        left_n = left_q - ONE;
                    else
                        st_n = tck_q ? ST_TCK : ST_REQ_HDR;
                end
                ST_TCK:     st_n = ST_REQ_HDR;
                ST_REQ_HDR: st_n = (chr_data == PPS_START) ? ST_REQ_FMT : ST_OFF;
                ST_REQ_FMT: begin
                    left_n = CNT_W'(opt_cnt);
                    st_n   = (opt_cnt != 3'd0) ? ST_REQ_OPT : ST_REQ_CHK;
                end
                ST_REQ_OPT: begin
                    if (left_q != ONE)
                        left_n = left_q - ONE;
                    else
                        st_n = ST_REQ_CHK;
                end
                ST_REQ_CHK: st_n = ST_RSP_HDR;
                ST_RSP_HDR: st_n = (chr_data == PPS_START) ? ST_RSP_FMT : ST_OFF;
                ST_RSP_FMT: begin
                    rflg_n = chr_data[6:4];
                    left_n = CNT_W'(opt_cnt);
                    st_n   = (opt_cnt != 3'd0) ? ST_RSP_OPT : ST_RSP_CHK;
                end
                ST_RSP_OPT: begin
                    // The rate byte, when flagged, is the first optional byte.
                    if (rflg_q[0] && !rseen_q) begin
                        rate_n  = chr_data;
                        rseen_n = 1'b1;
                    end
                    if (left_q != ONE)
                        left_n = left_q - ONE;
                    else
                        st_n = ST_RSP_CHK;
                end
                ST_RSP_CHK: begin
                    exch_done = 1'b1;
                    st_n      = ST_OFF;
                end
                default: st_n = ST_OFF;
            endcase
        end
    end

    // State and capture registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_OFF;
            left_q  <= '0;
            tdl_q   <= 1'b0;
            tck_q   <= 1'b0;
            hist_q  <= '0;
            rflg_q  <= '0;
            rate_q  <= '0;
            rseen_q <= 1'b0;
        end else begin
            st_q    <= st_n;
            left_q  <= left_n;
            tdl_q   <= tdl_n;
            tck_q   <= tck_n;
            hist_q  <= hist_n;
            rflg_q  <= rflg_n;
            rate_q  <= rate_n;
            rseen_q <= rseen_n;
        end
    end

    assign rate_byte = rate_q;
    assign rate_seen = rseen_q;

endmodule

// File: rtl/pps_rate_tracker.sv
// PPS exchange catcher top: follows a card session from reset and
// loads a new half-etu count into the line receiver on the cycle
// after the PPS response check byte of a valid exchange.
// Assumes a single clock, a one-cycle sess_start per reset rising
// edge, and one-cycle chr_valid strobes per character.
module pps_rate_tracker #(
    parameter int HETU_W   = 12,
    parameter int DEF_HETU = 186,
    parameter int CNT_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sess_start,
    input  logic              chr_valid,
    input  logic [7:0]        chr_data,
    output logic              hetu_load,
    output logic [HETU_W-1:0] hetu_val,
    output logic              chr_act
);

    localparam logic [HETU_W-1:0] HETU_RST = HETU_W'(DEF_HETU);

    logic              exch_done;
    logic [7:0]        rate_byte;
    logic              rate_seen;
    logic [HETU_W-1:0] lut_hetu;
    logic              lut_ok;

    pps_catch_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sess_start(sess_start),
        .chr_valid (chr_valid),
        .chr_data  (chr_data),
        .exch_done (exch_done),
        .rate_byte (rate_byte),
        .rate_seen (rate_seen)
    );

    pps_rate_lut #(.HETU_W(HETU_W)) u_lut (
        .rate_byte(rate_byte),
        .hetu     (lut_hetu),
        .rate_ok  (lut_ok)
    );

    // Output stage: default reload on session start, rate load on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hetu_load <= 1'b0;
            chr_act   <= 1'b0;
            hetu_val  <= HETU_RST;
        end else begin
            hetu_load <= 1'b0;
            chr_act   <= 1'b0;
            if (sess_start) begin
                hetu_load <= 1'b1;
                hetu_val  <= HETU_RST;
            end else if (exch_done) begin
                chr_act <= 1'b1;
                if (rate_seen && lut_ok) begin
                    hetu_load <= 1'b1;
                    hetu_val  <= lut_hetu;
                end
            end
        end
    end

endmodule

// File: rtl/pps_rate_tracker_chk.sv
// Port-level checker for the PPS exchange catcher, bound to the top.
module pps_rate_tracker_chk #(
    parameter int HETU_W   = 12,
    parameter int DEF_HETU = 186
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sess_start,
    input logic              chr_valid,
    input logic              hetu_load,
    input logic [HETU_W-1:0] hetu_val,
    input logic              chr_act
);

    logic act_seen;

    // Remembers that this session already produced its action.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_seen <= 1'b0;
        else if (sess_start)
            act_seen <= 1'b0;
        else if (chr_act)
            act_seen <= 1'b1;
    end

    // R2
    default_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sess_start |=> (hetu_load && !chr_act && hetu_val == HETU_W'(DEF_HETU)));

    // R12
    load_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hetu_load |-> ($past(chr_valid) || $past(sess_start)));

    // R8
    act_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chr_act |-> ($past(chr_valid) && !$past(sess_start)));

    // R11
    single_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chr_act |-> !act_seen);

    // R9
    load_with_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hetu_load && !$past(sess_start)) |-> chr_act);

    // R10
    val_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hetu_load |=> (!hetu_load || $past(sess_start) || $past(chr_valid)));

endmodule

bind pps_rate_tracker pps_rate_tracker_chk #(
    .HETU_W  (HETU_W),
    .DEF_HETU(DEF_HETU)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sess_start(sess_start),
    .chr_valid (chr_valid),
    .hetu_load (hetu_load),
    .hetu_val  (hetu_val),
    .chr_act   (chr_act)
);

// File: tb/pps_rate_tracker_bench.sv
module pps_rate_tracker_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HETU_W     = 12;
    localparam int DEF_HETU   = 186;
    localparam int MAXLEN     = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sess_start = 1'b0;
    logic              chr_valid = 1'b0;
    logic [7:0]        chr_data = '0;
    logic              hetu_load;
    logic [HETU_W-1:0] hetu_val;
    logic              chr_act;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] seq [MAXLEN];
    int         seq_len = 0;
    int         loads, acts, act_pos, load_pos, last_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    pps_rate_tracker #(.HETU_W(HETU_W), .DEF_HETU(DEF_HETU)) u_pps_rate_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .sess_start(sess_start),
        .chr_valid (chr_valid),
        .chr_data  (chr_data),
        .hetu_load (hetu_load),
        .hetu_val  (hetu_val),
        .chr_act   (chr_act)
    );

    task automatic check(input bit ok, input string tag, input int actual, input int expected);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic clear_seq();
        seq_len = 0;
    endtask

    task automatic put(input logic [7:0] b);
        seq[seq_len] = b;
        seq_len++;
    endtask

    // Pulse sess_start; return observed outputs one cycle later.
    task automatic start_session(output int ld, output int val, output int act);
        @(negedge clk);
        sess_start = 1'b1;
        @(negedge clk);
        sess_start = 1'b0;
        ld  = int'(hetu_load);
        val = int'(hetu_val);
        act = int'(chr_act);
    endtask

    // Send the queued characters back to back, recording strobe positions.
    task automatic play();
        loads = 0; acts = 0; act_pos = -1; load_pos = -1; last_val = -1;
        for (int i = 0; i < seq_len; i++) begin
            @(negedge clk);
            chr_valid = 1'b1;
            chr_data  = seq[i];
            @(negedge clk);
            chr_valid = 1'b0;
            if (chr_act) begin acts++; act_pos = i; end
            if (hetu_load) begin loads++; load_pos = i; last_val = int'(hetu_val); end
        end
    endtask

    function automatic int f_of(input int fi);
        case (fi)
            0, 1: return 372;
            2: return 558;
            3: return 744;
            4: return 1116;
            5: return 1488;
            6: return 1860;
            9: return 512;
            10: return 768;
            11: return 1024;
            12: return 1536;
            13: return 2048;
            default: return 0;
        endcase
    endfunction

    // Appends a plain request and response carrying the given rate byte.
    task automatic put_pps(input logic [7:0] rate);
        put(8'hFF); put(8'h10); put(rate); put(8'h00);
        put(8'hFF); put(8'h10); put(rate); put(8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int ld, val, act, f, d, expv;
        bit sup;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(hetu_load == 1'b0, "R1 load in reset", int'(hetu_load), 0);
        check(chr_act == 1'b0, "R1 act in reset", int'(chr_act), 0);
        check(hetu_val == HETU_W'(DEF_HETU), "R1 val in reset", int'(hetu_val), DEF_HETU);
        rst_n = 1'b1;

        // R1: no session started yet, whole exchange ignored
        clear_seq(); put(8'h3B); put(8'h00); put_pps(8'h94);
        play();
        check(acts == 0 && loads == 0, "R1 before session", acts + loads, 0);

        // R2: default reload on session start
        start_session(ld, val, act);
        check(ld == 1 && val == DEF_HETU && act == 0, "R2 default reload", val, DEF_HETU);
        @(negedge clk);
        check(hetu_load == 1'b0, "R12 one-cycle load", int'(hetu_load), 0);

        // R9 R10 R8: sweep every rate byte through a minimal exchange
        for (int p = 0; p < 256; p++) begin
            start_session(ld, val, act);
            clear_seq(); put(8'h3B); put(8'h00); put_pps(8'(p));
            play();
            f   = f_of(p >> 4);
            d   = p & 15;
            sup = (f != 0) && (d >= 1) && (d <= 7);
            expv = sup ? f / (2 * (1 << (d - 1))) : 0;
            check(acts == 1 && act_pos == 9, "R8 action on response check byte", act_pos, 9);
            if (sup)
                check(loads == 1 && load_pos == 9 && last_val == expv, "R9 rate load value", last_val, expv);
            else
                check(loads == 0 && hetu_val == HETU_W'(DEF_HETU), "R10 unsupported rate", loads, 0);
        end

        // R3: wrong initial character
        start_session(ld, val, act);
        clear_seq(); put(8'h3F); put(8'h00); put_pps(8'h94);
        play();
        check(acts == 0 && loads == 0, "R3 bad initial character", acts, 0);

        // R4: TA1 TC1 TD1(T=1) TD2 TA3 TB3, two historical bytes, TCK
        start_session(ld, val, act);
        clear_seq();
        put(8'h3B); put(8'hD2); put(8'h11); put(8'h00); put(8'h81); put(8'h31);
        put(8'hFE); put(8'h45); put(8'h41); put(8'h42); put(8'h5A);
        put_pps(8'h94);
        play();
        check(acts == 1 && act_pos == 18, "R4 ATR with TCK", act_pos, 18);
        check(loads == 1 && last_val == 32, "R4 load after long ATR", last_val, 32);

        // R4: TD1 with T=0 only, no TCK
        start_session(ld, val, act);
        clear_seq(); put(8'h3B); put(8'h80); put(8'h00); put_pps(8'h13);
        play();
        check(acts == 1 && act_pos == 10, "R4 ATR without TCK", act_pos, 10);

        // R4: history bytes that look like a request start
        start_session(ld, val, act);
        clear_seq(); put(8'h3B); put(8'h02); put(8'hFF); put(8'h10); put_pps(8'h95);
        play();
        check(acts == 1 && act_pos == 11 && last_val == 16, "R4 historical bytes skipped", act_pos, 11);

        // R5: byte after ATR is not 0xFF
        start_session(ld, val, act);
        clear_seq(); put(8'h3B); put(8'h00); put(8'hFE); put(8'h10); put(8'h94); put(8'h00);
        put_pps(8'h94);
        play();
        check(acts == 0 && loads == 0, "R5 bad request start", acts, 0);

        // R6: request with three optional bytes
        start_session(ld, val, act);
        clear_seq(); put(8'h3B); put(8'h00);
        put(8'hFF); put(8'h71); put(8'h94); put(8'hAA); put(8'hBB); put(8'hCC);
        put(8'hFF); put(8'h10); put(8'h94); put(8'h00);
        play();
        check(acts == 1 && act_pos == 11, "R6 request optional bytes", act_pos, 11);

        // R6: request with none
        start_session(ld, val, act);
        clear_seq(); put(8'h3B); put(8'h00);
        put(8'hFF); put(8'h00); put(8'h00);
        put(8'hFF); put(8'h10); put(8'h94); put(8'h00);
        play();
        check(acts == 1 && act_pos == 8, "R6 request without options", act_pos, 8);

        // R7: response does not start with 0xFF
        start_session(ld, val, act);
        clear_seq(); put(8'h3B); put(8'h00);
        put(8'hFF); put(8'h10); put(8'h94); put(8'h00);
        put(8'hFE); put(8'h10); put(8'h94); put(8'h00);
        play();
        check(acts == 0 && loads == 0, "R7 bad response start", acts, 0);

        // R10: response without rate byte, then with only the second option
        start_session(ld, val, act);
        clear_seq(); put(8'h3B); put(8'h00);
        put(8'hFF); put(8'h10); put(8'h94); put(8'h00);
        put(8'hFF); put(8'h00); put(8'h00);
        play();
        check(acts == 1 && loads == 0, "R10 response without rate", loads, 0);
        start_session(ld, val, act);
        clear_seq(); put(8'h3B); put(8'h00);
        put(8'hFF); put(8'h30); put(8'h94); put(8'h55); put(8'h00);
        put(8'hFF); put(8'h20); put(8'h94); put(8'h00);
        play();
        check(acts == 1 && loads == 0 && act_pos == 10, "R10 second option only", loads, 0);

        // R11: after the action, a fresh exchange is ignored
        clear_seq(); put(8'h3B); put(8'h00); put_pps(8'h94);
        play();
        check(acts == 0 && loads == 0, "R11 silent after action", acts + loads, 0);
        check(hetu_val == HETU_W'(DEF_HETU), "R11 value kept", int'(hetu_val), DEF_HETU);

        // R2: restart in the middle of an exchange
        start_session(ld, val, act);
        clear_seq(); put(8'h3B); put(8'h00); put(8'hFF); put(8'h10);
        play();
        start_session(ld, val, act);
        clear_seq(); put(8'h3B); put(8'h00); put_pps(8'h13);
        play();
        check(acts == 1 && last_val == 46, "R2 restart mid-exchange", last_val, 46);

        // R12: sess_start and chr_valid together, character dropped
        @(negedge clk);
        sess_start = 1'b1; chr_valid = 1'b1; chr_data = 8'h00;
        @(negedge clk);
        sess_start = 1'b0; chr_valid = 1'b0;
        check(hetu_load && !chr_act && hetu_val == HETU_W'(DEF_HETU), "R12 start wins", int'(hetu_val), DEF_HETU);
        clear_seq(); put(8'h3B); put(8'h00); put_pps(8'h94);
        play();
        check(acts == 1 && act_pos == 9, "R12 dropped character", act_pos, 9);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule